// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a bus-attached master for the two-wire PHY management interface. Software places an entire 32-bit management frame (start, opcode, PHY address, register address, turnaround and 16-bit data) into a single frame register. That write launches the transfer. The block generates the management clock MDC by dividing the system clock, optionally sends a run of idle-high preamble cycles, and then shifts the frame register out on MDIO, most significant bit first.

The frame register is the shift register. It rotates in place while the frame is on the wire, so its value is meaningless during a transfer. When a write frame ends, the register again holds the word that software wrote. On a read frame, the block releases MDIO for the second turnaround bit and for the data field. It samples the PHY's 16 data bits into the low half of the register, so that the register ends with the original upper half and the returned data below it. Completion sets a sticky event flag that drives the interrupt line. A status bit reports busy, so that software can avoid writing the frame register while a frame is in progress. Such a write overwrites the shifting word and corrupts the frame.

Register map (word address on `bus_addr`):
- 0: frame word.
- 1: control, with the clock divisor in bits [DIV_W-1:0] and the preamble-skip bit in bit 8.
- 2: event, with the completion flag in bit 0, write-one-to-clear.
- 3: status, with busy in bit 0.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `mdc_o` is low, `mdio_oe` and `mdio_o` are low and `irq_o` is low.
- R2: With a control divisor D > 0, MDC has a period of exactly 2·D system clocks. With D = 0, MDC is held low.
- R3: Writing the frame register while D > 0 and idle starts a frame, and status bit 0 reads 1 until completion. Writing it while D = 0 starts nothing, and status stays 0.
- R4: Unless control bit 8 is set, the frame is preceded by 32 MDC cycles with MDIO driven high. With bit 8 set, no preamble is sent.
- R5: Frame bits leave MSB first (word bit 31 first), one per MDC cycle, exactly 32 of them. MDIO and its enable change only right after a falling MDC edge.
- R6: A frame whose bits [29:28] are not 2'b10 is a write: all 32 bits are driven. Afterwards the frame register equals the written word.
- R7: A frame whose bits [29:28] are 2'b10 is a read: only frame bits 0..14 are driven. Bits 16..31 are sampled on rising MDC edges into register bits [15:0], MSB first, and bits [31:16] are restored.
- R8: Completion sets event bit 0, which drives `irq_o` and stays set until a write with data bit 0 = 1 to the event register. Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from pad |
| mdio_o | output | 1 | MDIO output to pad |
| mdio_oe | output | 1 | MDIO output enable |
| irq_o | output | 1 | Completion interrupt |

## Verification
The checker watches several properties on every cycle:
- MDIO and its enable move only after a falling MDC edge.
- The enable is never high while the engine is idle.
- A zero divisor holds MDC low and blocks any start.
- MDC rise and fall events never coincide.
- Completion is raised only on a falling edge.
- The event flag stays set until it is cleared.

The values on the wire can only be shown by the bench's frame sweeps across divisor, preamble and opcode: the bit order, the preamble length, the release point on reads, the restored register contents and the exact MDC period.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 32;
  localparam int PRE_BITS   = 32;
  localparam int SKIP_BIT   = 8;
  localparam int RELEASE_AT = 15;
  localparam int DATA_FIRST = 16;

  typedef enum logic [1:0] {ENG_IDLE, ENG_ARM, ENG_PRE, ENG_FRAME} eng_state_t;

  function automatic logic is_read_op(input logic [31:0] w);
    return w[29:28] == 2'b10;
  endfunction

  function automatic logic master_drives(input logic rd, input logic [4:0] idx);
    return !rd || (int'(idx) < RELEASE_AT);
  endfunction

  function automatic logic samples_bit(input logic rd, input logic [4:0] idx);
    return rd && (int'(idx) >= DATA_FIRST);
  endfunction

  function automatic logic [31:0] rotl1(input logic [31:0] w);
    return {w[30:0], w[31]};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = (div != '0) && (cnt >= div - DIV_W'(1));
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (div == '0) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_skip,
  input  logic             wr_clr,
  input  logic [31:0]      frame_word,
  input  logic             busy,
  input  logic             done_evt,
  output logic [DIV_W-1:0] div,
  output logic             skip_pre,
  output logic             frame_we,
  output logic             evt_flag,
  output logic [31:0]      rdata
);
  import mdio_pkg::*;

  logic ctrl_we, evt_we;

  assign frame_we = bus_sel && bus_wr && (bus_addr == 2'd0);
  assign ctrl_we  = bus_sel && bus_wr && (bus_addr == 2'd1);
  assign evt_we   = bus_sel && bus_wr && (bus_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div      <= '0;
      skip_pre <= 1'b0;
    end else if (ctrl_we) begin
      div      <= wr_div;
      skip_pre <= wr_skip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 evt_flag <= 1'b0;
    else if (done_evt)          evt_flag <= 1'b1;
    else if (evt_we && wr_clr)  evt_flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (bus_addr)
      2'd0: rdata = frame_word;
      2'd1: begin
        rdata[DIV_W-1:0] = div;
        rdata[SKIP_BIT]  = skip_pre;
      end
      2'd2: rdata[0] = evt_flag;
      default: rdata[0] = busy;
    endcase
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_we,
  input  logic [31:0] wdata,
  input  logic        div_nz,
  input  logic        skip_pre,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic [31:0] shreg,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done_evt
);
  import mdio_pkg::*;

  eng_state_t state;
  logic [4:0] pcnt;
  logic [4:0] fidx;
  logic       rd_op;
  logic       begin_frame, advance, sample_now;

  assign busy        = (state != ENG_IDLE);
  assign begin_frame = fall_evt && ((state == ENG_ARM && skip_pre) ||
                                    (state == ENG_PRE && pcnt == 5'd31));
  assign advance     = fall_evt && (state == ENG_FRAME) && (fidx != 5'd31);
  assign done_evt    = fall_evt && (state == ENG_FRAME) && (fidx == 5'd31);
  assign sample_now  = rise_evt && (state == ENG_FRAME) && samples_bit(rd_op, fidx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      pcnt    <= '0;
      fidx    <= '0;
      rd_op   <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      if (state == ENG_IDLE && frame_we && div_nz) begin
        state <= ENG_ARM;
        rd_op <= is_read_op(wdata);
      end
      if (begin_frame) begin
        state   <= ENG_FRAME;
        fidx    <= '0;
        mdio_o  <= shreg[31];
        mdio_oe <= 1'b1;
      end else if (fall_evt && state == ENG_ARM) begin
        state   <= ENG_PRE;
        pcnt    <= '0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end else if (fall_evt && state == ENG_PRE) begin
        pcnt <= pcnt + 5'd1;
      end else if (advance) begin
        fidx    <= fidx + 5'd1;
        mdio_o  <= shreg[31];
        mdio_oe <= master_drives(rd_op, fidx + 5'd1);
      end else if (done_evt) begin
        state   <= ENG_IDLE;
        mdio_o  <= 1'b0;
        mdio_oe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     shreg <= '0;
    else if (frame_we)              shreg <= wdata;
    else if (begin_frame || advance) shreg <= rotl1(shreg);
    else if (sample_now)            shreg <= {shreg[31:1], mdio_i};
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        irq_o
);
  import mdio_pkg::*;

  logic [DIV_W-1:0] div_val;
  logic             skip_pre, frame_we, evt_flag, busy, done_evt;
  logic             rise_evt, fall_evt;
  logic [31:0]      shreg;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .div(div_val),
    .mdc(mdc_o), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .wr_div(bus_wdata[DIV_W-1:0]),
    .wr_skip(bus_wdata[SKIP_BIT]), .wr_clr(bus_wdata[0]),
    .frame_word(shreg), .busy(busy), .done_evt(done_evt),
    .div(div_val), .skip_pre(skip_pre), .frame_we(frame_we),
    .evt_flag(evt_flag), .rdata(bus_rdata)
  );

  mdio_engine u_eng (
    .clk(clk), .rst_n(rst_n), .frame_we(frame_we), .wdata(bus_wdata),
    .div_nz(div_val != '0), .skip_pre(skip_pre),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .shreg(shreg), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done_evt(done_evt)
  );

  assign irq_o = evt_flag;
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_val,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             evt_flag,
  input logic             clr_req
);
  AST_MDC_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |=> !mdc_o);                                         // R2
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));                                           // R2
  AST_NO_START_DIV0: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && div_val == '0) |=> !busy);                                // R3
  AST_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);                                                  // R5
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $past(fall_evt));                              // R5
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $past(fall_evt));                             // R5
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(fall_evt));                               // R8
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !clr_req) |=> evt_flag);                               // R8
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_val(div_val), .mdc_o(mdc_o),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .evt_flag(evt_flag),
  .clr_req(bus_sel && bus_wr && bus_addr == 2'd2 && bus_wdata[0])
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc_o, mdio_i = 1'b0, mdio_o, mdio_oe, irq_o;

  int n_chk = 0, n_fail = 0;

  // monitor state
  logic        mon_en = 1'b0, started = 1'b0, mdc_prev = 1'b0;
  logic [63:0] oe_rec, val_rec;
  int          idx = 0, per_err = 0, cyc = 0, last_rise = 0;
  int          cur_div = 1, cur_pre = 32;
  logic        cur_rd = 1'b0;
  logic [15:0] phy_word = '0;

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc_o(mdc_o), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (mdio_oe) started = 1'b1;
      if (started && mdc_o && !mdc_prev) begin
        if (idx < 64) begin
          oe_rec[idx]  = mdio_oe;
          val_rec[idx] = mdio_o;
        end
        if (idx > 0 && (cyc - last_rise) != 2 * cur_div) per_err++;
        last_rise = cyc;
        idx++;
      end
      if (started && !mdc_o && mdc_prev) begin
        int n;
        n = idx - cur_pre;
        if (cur_rd && n >= 16 && n <= 31) mdio_i = phy_word[31 - n];
        else mdio_i = 1'b0;
      end
    end
    mdc_prev = mdc_o;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run_frame(input int dv, input bit skip, input bit rdop,
                           input logic [31:0] w, input logic [15:0] phy);
    logic [31:0] rv, expw;
    int waited, bad_pre, bad_frm;
    bus_write(2'd1, (32'(skip) << 8) | 32'(dv));
    bus_write(2'd2, 32'd1);
    cur_div = dv; cur_pre = skip ? 0 : 32; cur_rd = rdop; phy_word = phy;
    idx = 0; started = 1'b0; per_err = 0;
    mon_en = 1'b1;
    bus_write(2'd0, w);
    bus_read(2'd3, rv);
    chk("R3 busy during frame", rv, 32'd1);
    waited = 0;
    do begin @(negedge clk); waited++; end while (!irq_o && waited < 20000);
    mon_en = 1'b0;
    chk("R8 irq on completion", {31'd0, irq_o}, 32'd1);
    chk("R5 bit count", idx, cur_pre + 32);
    chk("R2 MDC period errors", per_err, 0);
    bad_pre = 0;
    for (int i = 0; i < cur_pre; i++)
      if (oe_rec[i] !== 1'b1 || val_rec[i] !== 1'b1) bad_pre++;
    chk("R4 preamble", bad_pre, 0);
    bad_frm = 0;
    for (int i = 0; i < 32; i++) begin
      logic eoe;
      eoe = !rdop || i < 15;
      if (oe_rec[cur_pre + i] !== eoe) bad_frm++;
      else if (eoe && val_rec[cur_pre + i] !== w[31 - i]) bad_frm++;
    end
    if (rdop) chk("R7 read frame drive/release", bad_frm, 0);
    else      chk("R6 write frame drive", bad_frm, 0);
    expw = rdop ? {w[31:16], phy} : w;
    bus_read(2'd0, rv);
    if (rdop) chk("R7 register after read", rv, expw);
    else      chk("R6 register after write", rv, expw);
    bus_read(2'd3, rv);
    chk("R3 idle after frame", rv, 32'd0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), rv);
      chk("R1 register reset", rv, 32'd0);
    end
    chk("R1 pins reset", {28'd0, mdc_o, mdio_oe, mdio_o, irq_o}, 32'd0);

    // R2/R3: divisor 0 holds MDC and blocks the start
    bus_write(2'd0, 32'h6000_0000);
    repeat (40) begin
      @(negedge clk);
      if (mdc_o !== 1'b0) begin n_chk++; n_fail++; $display("FAIL R2 mdc with div 0: actual 1 expected 0"); end
    end
    bus_read(2'd3, rv);
    chk("R3 no start with div 0", rv, 32'd0);
    chk("R3 no irq with div 0", {31'd0, irq_o}, 32'd0);

    // sweep of divisor, preamble and opcode
    for (int dv = 1; dv <= 3; dv++)
      for (int sk = 0; sk < 2; sk++)
        for (int rd = 0; rd < 2; rd++) begin
          logic [31:0] w;
          logic [15:0] dat;
          logic [4:0]  pa, ra;
          pa  = 5'(dv * 7 + sk * 3 + rd);
          ra  = 5'(dv * 5 + sk * 11 + rd * 2);
          dat = 16'hA5C3 ^ 16'(dv * 16'h1357 + sk * 16'h0F0F + rd * 16'h8001);
          w   = {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, dat};
          run_frame(dv, sk[0], rd[0], w, ~dat ^ 16'h3C5A);
        end

    // R8: write 0 leaves the flag, write 1 clears it
    bus_write(2'd2, 32'd0);
    chk("R8 write 0 keeps flag", {31'd0, irq_o}, 32'd1);
    bus_read(2'd2, rv);
    chk("R8 event register", rv, 32'd1);
    bus_write(2'd2, 32'd1);
    chk("R8 write 1 clears flag", {31'd0, irq_o}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule